// File: doc/BRIEF.md
# Reference-Loss Detector with Instant Feedback Re-Phase

This block sits beside a multiply-by-32 digital PLL whose reference is a very slow recovered clock (nominally 3.2 kHz). It runs entirely on the fast oscillator clock. The reference is brought into that domain through a synchronizer, and its rising edges are detected. The block also produces the divided feedback clock that the loop compares against the reference.

A timer measures how many oscillator cycles pass between recognised reference edges. If the reference stops, the timer runs out, and the block raises a hold output that freezes the loop filter. The block also gates off the phase detector's valid strobe so that no phase error reaches the filter. When the reference returns, the first new edge restarts the feedback divider, so the feedback rising edge lines up with that edge at once instead of being slewed by the loop. Hold is released only when the next edge also arrives within the timeout. A status flag and a one-cycle realign pulse make the recovery sequence visible.

There is no data stream here. Every pin is a plain level or strobe, so no valid/ready handshake or back-pressure applies.

Top module: `refloss_realign`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after reset, the outputs are as follows: hold is 1, ref_ok is 0, realign_pulse is 0, tdc_valid_out is 0, and fb_clk is 1 because the divider counter is 0.
- R2: A rising level on ref_in that is first sampled at clock edge k is recognised in the cycle between edges k+1 and k+2. Its effects appear on the registered outputs after edge k+2.
- R3: fb_clk comes from a free-running counter that counts 0 to DIV_RATIO-1 (default 32). fb_clk is high while the count is below DIV_RATIO/2 and low otherwise.
- R4: While locked (hold 0), consecutive recognised edges may be up to LOSS_CYCLES (default 48) cycles apart. If the LOSS_CYCLES-th cycle after the last edge passes with no edge, the block moves to the lost state on the next clock, with hold 1 and ref_ok 0.
- R5: In the lost state, the first recognised edge clears the divider. In the next cycle, fb_clk rises, realign_pulse is 1 for exactly one cycle, and ref_ok becomes 1 while hold stays 1.
- R6: After a realign, a recognised edge within LOSS_CYCLES cycles sets hold to 0. A gap longer than that returns the block to the lost state, with ref_ok 0.
- R7: Reference edges seen while locked or while waiting after a realign do not disturb the divider. fb_clk keeps its free-running sequence through reference period jitter.
- R8: tdc_valid_out equals tdc_valid_in while hold is 0 and is 0 whenever hold is 1, including the realign cycle.
- R9: Only rising transitions count. A reference stuck high produces no further edges and leads to loss exactly as a reference stuck low does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Recovered reference clock, asynchronous to osc_clk |
| tdc_valid_in | input | 1 | Valid strobe from the phase detector |
| fb_clk | output | 1 | Divided feedback clock (osc_clk / DIV_RATIO) |
| hold | output | 1 | Freezes the loop filter while the reference is missing or unconfirmed |
| ref_ok | output | 1 | Reference considered present (not in the lost state) |
| realign_pulse | output | 1 | One-cycle marker of a divider re-phase |
| tdc_valid_out | output | 1 | Phase detector strobe, masked while hold is 1 |

## Verification
The hardest conditions to reach are the exact timeout boundary and a late confirmation edge while the block is waiting after a realign. An edge gap of exactly LOSS_CYCLES must keep the lock, and a gap one cycle longer must drop it. The stimulus builds every reference waveform from cycle-counted high and low phases, so these gaps land on the exact cycle. It first places gaps of 48 and 49 cycles around a locked loop. It then sends a single edge after a loss followed by a 60-cycle silence, which forces the realign-then-timeout path. A behavioural model follows the expected state on every clock, and a directed probe checks the two-cycle synchronizer latency of the realign.

// File: rtl/lossdet_pkg.sv
package lossdet_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_LOST    = 2'd1,
    ST_REALIGN = 2'd2
  } lock_state_e;
endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // a level that stays high never yields a second edge
  assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int LIMIT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic late_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (edge_i)      cnt_q <= ONE;
    else if (cnt_q < LIM) cnt_q <= cnt_q + ONE;
  end

  assign late_o = (cnt_q >= LIM) & ~edge_i;

  assert_gap_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
  parameter int RATIO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic fb_clk_o
);
  localparam int W = $clog2(RATIO);
  localparam logic [W-1:0] LAST = W'(RATIO - 1);
  localparam logic [W-1:0] HALF = W'(RATIO / 2);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + W'(1);
  end

  assign fb_clk_o = (cnt_q < HALF);

  assert_div_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST && !clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/refloss_realign.sv
module refloss_realign
  import lossdet_pkg::*;
#(
  parameter int DIV_RATIO   = 32,
  parameter int LOSS_CYCLES = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic tdc_valid_in,
  output logic fb_clk,
  output logic hold,
  output logic ref_ok,
  output logic realign_pulse,
  output logic tdc_valid_out
);
  logic        ref_rise;
  logic        gap_late;
  logic        clear_div;
  logic        realign_q;
  lock_state_e state_q, state_d;

  refclk_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(osc_clk), .rst_n(rst_n), .async_in(ref_in), .rise_o(ref_rise)
  );

  gap_timer #(.LIMIT(LOSS_CYCLES)) timer_i (
    .clk(osc_clk), .rst_n(rst_n), .edge_i(ref_rise), .late_o(gap_late)
  );

  fb_divider #(.RATIO(DIV_RATIO)) div_i (
    .clk(osc_clk), .rst_n(rst_n), .clear_i(clear_div), .fb_clk_o(fb_clk)
  );

  assign clear_div = (state_q == ST_LOST) && ref_rise;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOCKED:  if (gap_late) state_d = ST_LOST;
      ST_LOST:    if (ref_rise) state_d = ST_REALIGN;
      ST_REALIGN: begin
        if (ref_rise)      state_d = ST_LOCKED;
        else if (gap_late) state_d = ST_LOST;
      end
      default:    state_d = ST_LOST;
    endcase
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOST;
      realign_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      realign_q <= clear_div;
    end
  end

  assign hold          = (state_q != ST_LOCKED);
  assign ref_ok        = (state_q != ST_LOST);
  assign realign_pulse = realign_q;
  assign tdc_valid_out = tdc_valid_in & ~hold;

  assert_hold_on_timeout_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(hold) |-> $past(gap_late));

  assert_release_on_edge_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $fell(hold) |-> $past(ref_rise));

  assert_realign_phase_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    realign_pulse |-> (fb_clk && hold && ref_ok));

  assert_realign_single_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    realign_pulse |=> !realign_pulse);

  assert_mask_valid_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
    realign_pulse |-> !tdc_valid_out);
endmodule

// File: tb/refloss_realign_tb_top.sv
`timescale 1ns/1ps
module refloss_realign_tb_top;
  localparam int DIV  = 32;
  localparam int LOSS = 48;

  logic osc_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic tdc_valid_in = 1'b0;
  logic fb_clk, hold, ref_ok, realign_pulse, tdc_valid_out;

  int checks = 0;
  int errors = 0;
  int realigns_seen = 0;
  int tv_cnt = 0;
  bit done = 1'b0;

  // model state: 0 locked, 1 lost, 2 waiting after realign
  int m_st = 1, m_gap = 0, m_div = 0;
  bit m_pulse = 1'b0, s_a = 1'b0, s_b = 1'b0, s_c = 1'b0;

  always #2 osc_clk = ~osc_clk;

  refloss_realign dut_i (
    .osc_clk(osc_clk), .rst_n(rst_n), .ref_in(ref_in), .tdc_valid_in(tdc_valid_in),
    .fb_clk(fb_clk), .hold(hold), .ref_ok(ref_ok), .realign_pulse(realign_pulse),
    .tdc_valid_out(tdc_valid_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge osc_clk) begin
    tv_cnt++;
    tdc_valid_in <= (tv_cnt % 3 == 0);
  end

  always @(posedge osc_clk) begin
    bit e, late;
    int nst;
    if (!rst_n) begin
      s_a = 0; s_b = 0; s_c = 0; m_st = 1; m_gap = 0; m_div = 0; m_pulse = 0;
    end else begin
      e = s_b && !s_c;
      late = (m_gap >= LOSS) && !e;
      nst = m_st;
      if (m_st == 0 && late) nst = 1;
      else if (m_st == 1 && e) nst = 2;
      else if (m_st == 2) begin
        if (e) nst = 0;
        else if (late) nst = 1;
      end
      m_pulse = (m_st == 1) && e;
      m_div = m_pulse ? 0 : (m_div + 1) % DIV;
      m_gap = e ? 1 : ((m_gap < LOSS) ? m_gap + 1 : m_gap);
      s_c = s_b; s_b = s_a; s_a = ref_in;
      m_st = nst;
    end
    #1;
    if (rst_n && !done) begin
      check(fb_clk == (m_div < DIV/2), "R3/R7 fb_clk", fb_clk, m_div < DIV/2);
      check(hold == (m_st != 0), "R4/R6/R9 hold", hold, m_st != 0);
      check(ref_ok == (m_st != 1), "R4/R5 ref_ok", ref_ok, m_st != 1);
      check(realign_pulse == m_pulse, "R5 realign_pulse", realign_pulse, m_pulse);
      check(tdc_valid_out == (tdc_valid_in && m_st == 0), "R8 tdc_valid_out",
            tdc_valid_out, tdc_valid_in && m_st == 0);
      if (realign_pulse) realigns_seen++;
    end
  end

  task automatic ref_cycle(input int hi, input int lo);
    ref_in = 1'b1;
    repeat (hi) @(negedge osc_clk);
    ref_in = 1'b0;
    repeat (lo) @(negedge osc_clk);
  endtask

  // called from the lost state at a falling edge; probes the R2 latency
  task automatic align_probe();
    ref_in = 1'b1;
    @(posedge osc_clk); @(posedge osc_clk); #1;
    check(realign_pulse == 1'b0, "R2 no pulse before second edge", realign_pulse, 0);
    @(posedge osc_clk); #1;
    check(realign_pulse == 1'b1, "R2/R5 pulse after edge k+2", realign_pulse, 1);
    check(fb_clk == 1'b1, "R5 fb_clk rises with realign", fb_clk, 1);
    @(negedge osc_clk);
    repeat (13) @(negedge osc_clk);
    ref_in = 1'b0;
    repeat (16) @(negedge osc_clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (4) @(negedge osc_clk);
    check(hold == 1'b1, "R1 hold in reset", hold, 1);
    check(ref_ok == 1'b0, "R1 ref_ok in reset", ref_ok, 0);
    check(realign_pulse == 1'b0, "R1 pulse in reset", realign_pulse, 0);
    check(fb_clk == 1'b1, "R1 fb_clk in reset", fb_clk, 1);
    check(tdc_valid_out == 1'b0, "R1 valid in reset", tdc_valid_out, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge osc_clk);
    align_probe();
    for (int i = 0; i < 8; i++) ref_cycle(16, 16);
    ref_cycle(15, 15); ref_cycle(17, 17); ref_cycle(14, 16); ref_cycle(16, 18);
    ref_cycle(16, 32);                              // gap of exactly 48
    for (int i = 0; i < 3; i++) ref_cycle(16, 16);
    ref_cycle(16, 33);                              // gap of 49: loss
    for (int i = 0; i < 6; i++) ref_cycle(16, 16);
    repeat (120) @(negedge osc_clk);                // reference stuck low
    check(hold == 1'b1 && ref_ok == 1'b0, "R4 lost after silence", hold, 1);
    repeat (7) @(negedge osc_clk);
    for (int i = 0; i < 6; i++) ref_cycle(16, 16);
    repeat (100) @(negedge osc_clk);
    ref_cycle(16, 44);                              // realign then late confirm
    ref_cycle(16, 16);
    for (int i = 0; i < 5; i++) ref_cycle(16, 16);
    ref_in = 1'b1;
    repeat (120) @(negedge osc_clk);                // reference stuck high
    check(hold == 1'b1 && ref_ok == 1'b0, "R9 lost while stuck high", hold, 1);
    ref_in = 1'b0;
    repeat (5) @(negedge osc_clk);
    for (int i = 0; i < 6; i++) ref_cycle(16, 16);
    check(hold == 1'b0, "R6 relocked at end", hold, 0);
    check(realigns_seen >= 6, "R5 realign count", realigns_seen, 6);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge osc_clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog requirement none actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule